// File: doc/BRIEF.md
# Watchdog Timer with Start-up Hold

This block supervises a processor core. A watchdog counter advances on ticks taken either from a slow oscillator enable or from the system clock divided by four. The ticks pass through a prescaler with a selectable power-of-two ratio and then through a fixed-width counter. If software fails to clear the watchdog in time, the counter overflows. An overflow while the core runs restarts the core. An overflow while the core is halted only wakes it. Software clears the watchdog with two kinds of clear strobe. A configuration bit chooses whether either strobe clears it on its own, or whether both kinds must have arrived.

A start-up sequencer holds the core in reset for a fixed number of system clocks after every restart: power-up, external reset, watchdog time-out in run, or wake from halt. Two status flags report the cause of the last wake-up or reset. The time-out flag is set by an overflow. The power-down flag is set by halt entry. Both flags clear on a watchdog clear by software.

Top module: `wdt_sst_top`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1 and `to_flag` and `pd_flag` are 0. After `rst_n` rises, `core_rst` stays 1 for exactly SST_CYCLES + SYNC_STAGES clocks (1026 with defaults) and then falls.
- R2: `core_rst` is 1 in every cycle that follows a cycle with `ext_rst_req` high. After any later restart, `core_rst` stays 1 for exactly SST_CYCLES clocks, counted from the restart edge or, for an external reset, from the last edge on which `ext_rst_req` was high.
- R3: With `cfg_src_osc`=0 the watchdog ticks once every 4 clocks. With `cfg_ratio`=0, `core_rst` rises 4*2^CNT_W clocks (1024) after it fell. At that point `wdt_timeout` pulses and `to_flag` becomes 1.
- R4: A value k on `cfg_ratio` (0..7) divides the tick rate by 2^k, so the run time with the system clock source is 4*2^(k+CNT_W) clocks.
- R5: With `cfg_src_osc`=1, each high cycle of `osc_tick` is one tick. The watchdog overflows on tick number 2^(k+CNT_W), regardless of the spacing between ticks.
- R6: With `cfg_wdt_en`=0 the counter is held cleared and no time-out occurs.
- R7: With `cfg_dual_clr`=0, a strobe on either `clr_a` or `clr_b` in run clears the prescaler and counter and clears `to_flag` and `pd_flag`. The next time-out comes 4*2^(k+CNT_W) clocks after the strobe's edge.
- R8: With `cfg_dual_clr`=1, the watchdog and the flags clear only once both strobe kinds have been seen, in either order or together. A repeat of the same kind does not count twice.
- R9: A `halt_enter` strobe in run enters halt, clears the counter, sets `pd_flag` and clears `to_flag`. Clear strobes have no effect on the flags during halt or start-up.
- R10: In halt, the system clock source gives no ticks, while the oscillator source keeps counting. An overflow in halt sets `to_flag`, leaves `pd_flag` at 1 and starts the start-up hold.
- R11: A `wake_evt` in halt starts the start-up hold and leaves both flags unchanged.
- R12: An external reset leaves both flags unchanged. A time-out in run sets `to_flag` and leaves `pd_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| ext_rst_req | input | 1 | External reset request, level, synchronous |
| osc_tick | input | 1 | Watchdog oscillator enable, one tick per high cycle |
| cfg_wdt_en | input | 1 | Watchdog enable |
| cfg_src_osc | input | 1 | 1: oscillator ticks, 0: system clock divided by 4 |
| cfg_ratio | input | RATIO_W | Prescaler ratio exponent |
| cfg_dual_clr | input | 1 | 1: both strobe kinds needed to clear |
| clr_a | input | 1 | Clear strobe, first kind |
| clr_b | input | 1 | Clear strobe, second kind |
| halt_enter | input | 1 | Halt entry strobe |
| wake_evt | input | 1 | Wake event from halt |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| core_rst | output | 1 | Holds the core in reset |
| wdt_timeout | output | 1 | One-cycle pulse on watchdog overflow |

## Verification
The properties assume three things about the inputs. Configuration inputs change only while `core_rst` is high, or while the watchdog is disabled. Clear, halt and wake strobes last one cycle. Strobes from the core arrive only while it runs. The stimulus keeps to these rules: it changes configuration only during a start-up hold, drives every strobe for a single cycle, and spaces oscillator ticks randomly from a fixed seed. Directed cases cover the strobe orderings of the two-strobe clear mode, halt with each tick source, and an external reset while the watchdog is disabled.

// File: rtl/wdt_sst_pkg.sv
package wdt_sst_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_HALT  = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
  parameter int SYS_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic halted,
  input  logic src_osc,
  input  logic osc_tick,
  output logic tick
);
  localparam int DIV_W = $clog2(SYS_DIV);

  logic [DIV_W-1:0] div_q, div_d;
  logic             sys_tick;

  // the system clock is considered stopped while halted
  assign sys_tick = !halted && (div_q == DIV_W'(SYS_DIV - 1));

  always_comb begin
    div_d = div_q;
    if (clr)         div_d = '0;
    else if (!halted) div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = src_osc ? osc_tick : sys_tick;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int RATIO_W = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               ovf
);
  localparam int PRE_W = (1 << RATIO_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, sel_mask;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_full, adv;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign sel_mask[i] = (int'(ratio) > i);
  end

  assign pre_full = ((pre_q & sel_mask) == sel_mask);
  assign adv      = tick && pre_full;
  assign ovf      = !clr && adv && (&cnt_q);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (clr) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = pre_q + PRE_W'(1);
      if (adv) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdt_clr_arb.sv
module wdt_clr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic run_ok,
  input  logic dual,
  input  logic clr_a,
  input  logic clr_b,
  output logic fire
);
  logic seen_a_q, seen_b_q, seen_a_d, seen_b_d;
  logic got_a, got_b;

  assign got_a = seen_a_q || clr_a;
  assign got_b = seen_b_q || clr_b;

  always_comb begin
    fire = 1'b0;
    if (run_ok) fire = dual ? (got_a && got_b) : (clr_a || clr_b);
  end

  always_comb begin
    seen_a_d = 1'b0;
    seen_b_d = 1'b0;
    if (run_ok && dual && !fire) begin
      seen_a_d = got_a;
      seen_b_d = got_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      seen_a_q <= seen_a_d;
      seen_b_q <= seen_b_d;
    end
  end
endmodule

// File: rtl/wdt_sst_top.sv
module wdt_sst_top #(
  parameter int SST_CYCLES  = 1024,
  parameter int CNT_W       = 8,
  parameter int RATIO_W     = 3,
  parameter int SYS_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_rst_req,
  input  logic               osc_tick,
  input  logic               cfg_wdt_en,
  input  logic               cfg_src_osc,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               cfg_dual_clr,
  input  logic               clr_a,
  input  logic               clr_b,
  input  logic               halt_enter,
  input  logic               wake_evt,
  output logic               to_flag,
  output logic               pd_flag,
  output logic               core_rst,
  output logic               wdt_timeout
);
  import wdt_sst_pkg::*;

  localparam int SST_W = $clog2(SST_CYCLES);

  wd_state_e        st_q, st_d;
  logic [SST_W-1:0] sst_q, sst_d;
  logic             rst_n_sync;
  logic             sst_done, restart;
  logic             run_ok, halt_go, sw_fire, wd_clr, wd_tick, wdt_ovf;
  logic             to_q, to_d, pd_q, pd_d;
  logic             halted;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign halted  = (st_q == ST_HALT);
  assign run_ok  = (st_q == ST_RUN) && !ext_rst_req && !halt_enter;
  assign halt_go = (st_q == ST_RUN) && !ext_rst_req && halt_enter;
  assign wd_clr  = !cfg_wdt_en || ext_rst_req || (st_q == ST_START) || halt_go || sw_fire;

  wdt_clr_arb u_clr_arb (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .run_ok (run_ok),
    .dual   (cfg_dual_clr),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .fire   (sw_fire)
  );

  wdt_tick_src #(.SYS_DIV(SYS_DIV)) u_tick_src (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .clr      (wd_clr),
    .halted   (halted),
    .src_osc  (cfg_src_osc),
    .osc_tick (osc_tick),
    .tick     (wd_tick)
  );

  wdt_count #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (wd_clr),
    .tick  (wd_tick),
    .ratio (cfg_ratio),
    .ovf   (wdt_ovf)
  );

  assign sst_done = (st_q == ST_START) && (sst_q == SST_W'(SST_CYCLES - 1));

  // sequencer: external reset has priority over every other event
  always_comb begin
    st_d    = st_q;
    restart = 1'b0;
    if (ext_rst_req) begin
      st_d    = ST_START;
      restart = 1'b1;
    end else begin
      case (st_q)
        ST_START: if (sst_done) st_d = ST_RUN;
        ST_RUN: begin
          if (halt_enter) st_d = ST_HALT;
          else if (wdt_ovf) begin
            st_d    = ST_START;
            restart = 1'b1;
          end
        end
        ST_HALT: begin
          if (wdt_ovf || wake_evt) begin
            st_d    = ST_START;
            restart = 1'b1;
          end
        end
        default: st_d = ST_START;
      endcase
    end
  end

  always_comb begin
    sst_d = '0;
    if ((st_q == ST_START) && !restart && !sst_done) sst_d = sst_q + SST_W'(1);
  end

  // status flags: halt entry over software clear over overflow
  always_comb begin
    to_d = to_q;
    pd_d = pd_q;
    if (!ext_rst_req) begin
      if (halt_go) begin
        pd_d = 1'b1;
        to_d = 1'b0;
      end else if (sw_fire) begin
        pd_d = 1'b0;
        to_d = 1'b0;
      end else if (wdt_ovf) begin
        to_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      st_q  <= ST_START;
      sst_q <= '0;
      to_q  <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sst_q <= sst_d;
      to_q  <= to_d;
      pd_q  <= pd_d;
    end
  end

  assign core_rst    = (st_q == ST_START);
  assign to_flag     = to_q;
  assign pd_flag     = pd_q;
  assign wdt_timeout = wdt_ovf;
endmodule

// File: rtl/wdt_sst_chk.sv
module wdt_sst_chk #(
  parameter int SST_CYCLES = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic ext_rst_req,
  input logic cfg_wdt_en,
  input logic cfg_dual_clr,
  input logic clr_a,
  input logic clr_b,
  input logic halt_enter,
  input logic wake_evt,
  input logic in_halt,
  input logic to_flag,
  input logic pd_flag,
  input logic core_rst,
  input logic wdt_timeout
);
  localparam int HW = $clog2(SST_CYCLES + 2) + 1;

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hold_q <= '0;
    else if (ext_rst_req || !core_rst) hold_q <= '0;
    else if (hold_q != '1)          hold_q <= hold_q + HW'(1);
  end

  p_hold_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (hold_q == HW'(SST_CYCLES)));

  p_ext_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> core_rst);

  p_timeout_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && !ext_rst_req) |=> (core_rst && to_flag));

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wdt_en |-> !wdt_timeout);

  p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dual_clr && (clr_a || clr_b) && !core_rst && !in_halt && !halt_enter && !ext_rst_req)
      |=> (!to_flag && !pd_flag));

  p_halt_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_enter && !core_rst && !in_halt && !ext_rst_req) |=> (in_halt && pd_flag && !to_flag));

  p_halt_pd_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && !ext_rst_req) |=> $stable(pd_flag));

  p_wake_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && wake_evt && !ext_rst_req) |=> (core_rst && !in_halt));

  p_ext_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> ($stable(to_flag) && $stable(pd_flag)));
endmodule

bind wdt_sst_top wdt_sst_chk #(.SST_CYCLES(SST_CYCLES)) u_wdt_sst_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .ext_rst_req  (ext_rst_req),
  .cfg_wdt_en   (cfg_wdt_en),
  .cfg_dual_clr (cfg_dual_clr),
  .clr_a        (clr_a),
  .clr_b        (clr_b),
  .halt_enter   (halt_enter),
  .wake_evt     (wake_evt),
  .in_halt      (halted),
  .to_flag      (to_flag),
  .pd_flag      (pd_flag),
  .core_rst     (core_rst),
  .wdt_timeout  (wdt_timeout)
);

// File: tb/test_wdt_sst_top.sv
module test_wdt_sst_top;
  localparam int CLK_PERIOD = 10;
  localparam int SST        = 1024;
  localparam int CW         = 8;
  localparam int SYNC       = 2;
  localparam int LIMIT      = 100000;

  logic       clk = 1'b0;
  logic       rst_n, ext_rst_req, osc_tick;
  logic       cfg_wdt_en, cfg_src_osc, cfg_dual_clr;
  logic [2:0] cfg_ratio;
  logic       clr_a, clr_b, halt_enter, wake_evt;
  logic       to_flag, pd_flag, core_rst, wdt_timeout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_sst_top i_wdt_sst_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_rst_req  (ext_rst_req),
    .osc_tick     (osc_tick),
    .cfg_wdt_en   (cfg_wdt_en),
    .cfg_src_osc  (cfg_src_osc),
    .cfg_ratio    (cfg_ratio),
    .cfg_dual_clr (cfg_dual_clr),
    .clr_a        (clr_a),
    .clr_b        (clr_b),
    .halt_enter   (halt_enter),
    .wake_evt     (wake_evt),
    .to_flag      (to_flag),
    .pd_flag      (pd_flag),
    .core_rst     (core_rst),
    .wdt_timeout  (wdt_timeout)
  );

  function automatic int exp_run(input int ratio, input bit osc);
    return (osc ? 1 : 4) << (ratio + CW);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts clocks while core_rst stays high
  task automatic hold_len(output int n);
    n = 0;
    while (core_rst && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  // counts clocks while core_rst stays low
  task automatic run_len(output int n);
    n = 0;
    while (!core_rst && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  // 0: clr_a, 1: clr_b, 2: both, 3: halt_enter, 4: wake_evt
  task automatic strobe(input int which);
    case (which)
      0: clr_a = 1'b1;
      1: clr_b = 1'b1;
      2: begin clr_a = 1'b1; clr_b = 1'b1; end
      3: halt_enter = 1'b1;
      default: wake_evt = 1'b1;
    endcase
    @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0; halt_enter = 1'b0; wake_evt = 1'b0;
  endtask

  // oscillator ticks with random gaps until core_rst rises
  task automatic osc_run(output int cnt);
    cnt = 0;
    while (!core_rst && cnt < LIMIT) begin
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      cnt++;
      if (!core_rst) repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int r;
    int seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; ext_rst_req = 1'b0; osc_tick = 1'b0;
    cfg_wdt_en = 1'b1; cfg_src_osc = 1'b0; cfg_ratio = 3'd0; cfg_dual_clr = 1'b0;
    clr_a = 1'b0; clr_b = 1'b0; halt_enter = 1'b0; wake_evt = 1'b0;
    cycles(3);
    chk("R1 core_rst in reset", core_rst, 1);
    chk("R1 to_flag in reset", to_flag, 0);
    chk("R1 pd_flag in reset", pd_flag, 0);
    rst_n = 1'b1;
    hold_len(n);
    chk("R1 power-up hold", n, SST + SYNC);
    chk("R1 flags after power-up", {to_flag, pd_flag}, 0);

    // R3: system clock source, ratio 0
    run_len(n);
    chk("R3 run length", n, exp_run(0, 1'b0));
    chk("R3 to_flag after time-out", to_flag, 1);
    chk("R12 pd_flag after run time-out", pd_flag, 0);

    // R4: prescaler ratio 2
    cfg_ratio = 3'd2;
    hold_len(n);
    chk("R2 hold after time-out", n, SST);
    run_len(n);
    chk("R4 run length ratio 2", n, exp_run(2, 1'b0));

    // R5: oscillator source, random ratio and spacing
    for (int it = 0; it < 2; it++) begin
      r = $urandom % 3;
      cfg_src_osc = 1'b1;
      cfg_ratio = 3'(r);
      hold_len(n);
      chk("R2 hold before oscillator run", n, SST);
      osc_run(n);
      chk("R5 oscillator ticks to overflow", n, exp_run(r, 1'b1));
      chk("R5 to_flag", to_flag, 1);
    end

    // R6: disabled watchdog
    cfg_src_osc = 1'b0;
    cfg_ratio = 3'd0;
    cfg_wdt_en = 1'b0;
    hold_len(n);
    chk("R2 hold before disabled run", n, SST);
    run_len(n);
    n = 0;
    cycles(0);
    chk("R6 no time-out while disabled", core_rst, 0);
    begin
      int hi = 0;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (core_rst) hi++;
      end
      chk("R6 core_rst stays low 3000 clocks", hi, 0);
    end

    // R2/R12: external reset
    ext_rst_req = 1'b1;
    cfg_wdt_en = 1'b1;
    begin
      int lo = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (!core_rst) lo++;
      end
      chk("R2 core_rst held during external reset", lo, 0);
    end
    ext_rst_req = 1'b0;
    chk("R12 to_flag kept by external reset", to_flag, 1);
    hold_len(n);
    chk("R2 hold after external reset", n, SST);

    // R7: single clear mode
    cycles(700);
    strobe(0);
    chk("R7 flags cleared by clr_a", {to_flag, pd_flag}, 0);
    cycles(700);
    strobe(1);
    chk("R7 no time-out after clears", core_rst, 0);
    run_len(n);
    chk("R7 run after clr_b", n, exp_run(0, 1'b0));

    // R8: dual clear mode, a a b
    cfg_dual_clr = 1'b1;
    hold_len(n);
    cycles(100);
    strobe(0);
    chk("R8 single clr_a does not clear", to_flag, 1);
    cycles(100);
    strobe(0);
    chk("R8 repeated clr_a does not clear", to_flag, 1);
    cycles(100);
    strobe(1);
    chk("R8 clr_b after clr_a clears", to_flag, 0);
    run_len(n);
    chk("R8 run after a-then-b clear", n, exp_run(0, 1'b0));
    // b then a
    hold_len(n);
    r = 20 + ($urandom % 200);
    cycles(r);
    strobe(1);
    chk("R8 single clr_b does not clear", to_flag, 1);
    cycles(50);
    strobe(0);
    chk("R8 clr_a after clr_b clears", to_flag, 0);
    run_len(n);
    chk("R8 run after b-then-a clear", n, exp_run(0, 1'b0));
    // both together
    hold_len(n);
    cycles(10);
    strobe(2);
    chk("R8 simultaneous strobes clear", to_flag, 0);
    run_len(n);
    chk("R8 run after simultaneous clear", n, exp_run(0, 1'b0));

    // R9-R11: halt with system clock source
    cfg_dual_clr = 1'b0;
    hold_len(n);
    cycles(200);
    strobe(3);
    chk("R9 pd_flag on halt", pd_flag, 1);
    chk("R9 to_flag on halt", to_flag, 0);
    begin
      int hi = 0;
      for (int c = 0; c < 5000; c++) begin
        @(negedge clk);
        if (core_rst) hi++;
      end
      chk("R10 no ticks from system clock in halt", hi, 0);
    end
    strobe(0);
    chk("R9 clear ignored in halt", pd_flag, 1);
    strobe(4);
    hold_len(n);
    chk("R11 hold after wake event", n, SST);
    chk("R11 flags kept by wake", {to_flag, pd_flag}, 1);
    run_len(n);
    chk("R12 run after wake", n, exp_run(0, 1'b0));
    chk("R12 pd_flag kept by run time-out", {to_flag, pd_flag}, 3);

    // R10: halt with oscillator source
    cfg_src_osc = 1'b1;
    cfg_ratio = 3'd0;
    hold_len(n);
    cycles(5);
    strobe(3);
    chk("R9 flags on second halt", {to_flag, pd_flag}, 1);
    osc_run(n);
    chk("R10 oscillator ticks to overflow in halt", n, exp_run(0, 1'b1));
    chk("R10 flags after halt overflow", {to_flag, pd_flag}, 3);
    hold_len(n);
    chk("R10 hold after halt overflow", n, SST);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule